// File: doc/BRIEF.md
# Register Stack Frame Marker Unit

This unit holds the frame marker of a register file whose upper logical registers form a stack of procedure frames, and performs the marker changes caused by the three frame operations: allocate, call and return. Logical registers below 32 are fixed. Logical registers from 32 to 127 are relative to the current frame. The unit maps them onto a circular physical stacked file and flags any access that lies beyond the current frame.

An operation is presented for one cycle on `op_valid`, with `op_code` and, for an allocate, the four operands: inputs, locals, outputs and rotating size. A call keeps only the caller's output registers visible and saves the whole current marker. A return brings the saved marker back. An allocate reshapes the current frame and emits the saved marker on a one-cycle write port, so that it can be stored in the general register named by the instruction. One saved level is kept. Deeper nesting is left to software, which saves the saved marker itself. Translation is combinational from `lreg`.

Top module: `rstk_frame_unit`

## Requirements
- R1: After reset, the current marker, the saved marker and the physical frame base are all zero. Every logical register from 32 upward then reports a range fault.
- R2: A logical register below 32 maps to a physical index equal to its own number. `phys_static` is set for it, and it never faults.
- R3: The marker is 38 bits wide with these fields: frame size in [6:0], locals size in [13:7], rotating size (in units of 8 registers) in [17:14], and three rotating bases in [24:18], [31:25] and [37:32]. The rotating bases always read as zero.
- R4: An allocate with operands (i, l, o, r) sets locals = i+l, frame size = i+l+o and rotating size = r, and leaves the saved marker unchanged. One cycle after the operation, `alloc_wr_valid` pulses for one cycle and `alloc_wr_data` holds the saved marker.
- R5: An allocate faults when i+l+o exceeds 96 or when r*8 exceeds i+l+o. On a fault, `alloc_fault` pulses for one cycle, no write pulse is given, and both markers and the base stay unchanged.
- R6: A call copies the current marker into the saved marker. The new current marker has frame size = old frame size − old locals, and locals, rotating size and bases all zero. The physical base advances by the old locals, modulo the physical stacked-file size.
- R7: A return loads the current marker from the saved marker and leaves the saved marker unchanged. The physical base moves back by the restored locals, modulo the physical stacked-file size.
- R8: For a logical register n ≥ 32 with offset k = n−32, `reg_fault` is set when k ≥ frame size. Otherwise `phys_idx` = (base + k) modulo the physical stacked-file size.
- R9: The opcode encoding is allocate = 0, call = 1, return = 2. Opcode 3 has no effect on any state or output, and neither has any opcode while `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle |
| op_code | input | 2 | 0 allocate, 1 call, 2 return, 3 no operation |
| alloc_ins | input | 7 | Allocate operand: input registers |
| alloc_locs | input | 7 | Allocate operand: local registers |
| alloc_outs | input | 7 | Allocate operand: output registers |
| alloc_rot | input | 4 | Allocate operand: rotating size in units of 8 |
| lreg | input | 7 | Logical register number to translate |
| cfm | output | 38 | Current frame marker |
| pfm | output | 38 | Saved previous frame marker |
| alloc_wr_valid | output | 1 | One-cycle pulse after a successful allocate |
| alloc_wr_data | output | 38 | Saved marker to be written to the allocate target |
| alloc_fault | output | 1 | One-cycle pulse after a rejected allocate |
| phys_idx | output | PIDX_W | Physical index of `lreg` |
| phys_static | output | 1 | `lreg` is a fixed register |
| reg_fault | output | 1 | `lreg` lies beyond the current frame |

## Verification
After each operation, the bench sweeps all 128 logical registers. This separates the identity mapping of fixed registers, the exact first faulting offset at the frame edge, and the modular placement of stacked registers. It uses a physical file of 100 entries, which is not a power of two, so that wrap-around is tested by true subtraction rather than by dropping bits. The operation pattern covers:
- an allocate → call → allocate → return chain, which tells apart the saved-marker copy, the shrink to output registers, and the restore;
- two successive calls and returns, whose base crosses the end of the file in both directions;
- rejected allocates of both kinds, a full 96-register frame, and inert opcode inputs, each confirming that nothing moves.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  localparam int unsigned SOF_W   = 7;
  localparam int unsigned SOR_W   = 4;
  localparam int unsigned RRBG_W  = 7;
  localparam int unsigned RRBF_W  = 7;
  localparam int unsigned RRBP_W  = 6;
  localparam int unsigned MARK_W  = 2 * SOF_W + SOR_W + RRBG_W + RRBF_W + RRBP_W;
  localparam int unsigned LREG_W  = 7;
  localparam int unsigned NUM_FIXED   = 32;
  localparam int unsigned NUM_STACKED = 96;
  localparam int unsigned SUM_W   = SOF_W + 2;

  // Packed MSB first, so the frame size lands in the low bits.
  typedef struct packed {
    logic [RRBP_W-1:0] rrb_pr;
    logic [RRBF_W-1:0] rrb_fr;
    logic [RRBG_W-1:0] rrb_gr;
    logic [SOR_W-1:0]  sor;
    logic [SOF_W-1:0]  sol;
    logic [SOF_W-1:0]  sof;
  } frame_t;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  function automatic logic [SUM_W-1:0] frame_locals(input logic [SOF_W-1:0] ins,
                                                    input logic [SOF_W-1:0] locs);
    return SUM_W'(ins) + SUM_W'(locs);
  endfunction

  function automatic logic [SUM_W-1:0] frame_total(input logic [SOF_W-1:0] ins,
                                                   input logic [SOF_W-1:0] locs,
                                                   input logic [SOF_W-1:0] outs);
    return frame_locals(ins, locs) + SUM_W'(outs);
  endfunction

  function automatic logic [SUM_W-1:0] rot_regs(input logic [SOR_W-1:0] rot);
    return SUM_W'({rot, 3'b000});
  endfunction

  // Modular step forward on a ring of p entries; n never exceeds p.
  function automatic int unsigned ring_add(input int unsigned b,
                                           input int unsigned n,
                                           input int unsigned p);
    int unsigned s;
    s = b + n;
    return (s >= p) ? s - p : s;
  endfunction

  function automatic int unsigned ring_sub(input int unsigned b,
                                           input int unsigned n,
                                           input int unsigned p);
    return (b >= n) ? b - n : b + p - n;
  endfunction

endpackage

// File: rtl/rstk_alloc_eval.sv
module rstk_alloc_eval
  import rstk_pkg::*;
(
  input  frame_t            cur,
  input  logic [SOF_W-1:0]  ins,
  input  logic [SOF_W-1:0]  locs,
  input  logic [SOF_W-1:0]  outs,
  input  logic [SOR_W-1:0]  rot,
  output frame_t            next_frame,
  output logic              ok,
  output logic              too_big,
  output logic              rot_over
);
  logic [SUM_W-1:0] sum_l;
  logic [SUM_W-1:0] sum_f;

  always_comb begin
    sum_l    = frame_locals(ins, locs);
    sum_f    = frame_total(ins, locs, outs);
    too_big  = sum_f > SUM_W'(NUM_STACKED);
    rot_over = rot_regs(rot) > sum_f;
    ok       = !too_big && !rot_over;
    next_frame        = cur;
    next_frame.sof    = sum_f[SOF_W-1:0];
    next_frame.sol    = sum_l[SOF_W-1:0];
    next_frame.sor    = rot;
    next_frame.rrb_gr = '0;
    next_frame.rrb_fr = '0;
    next_frame.rrb_pr = '0;
  end
endmodule

// File: rtl/rstk_base_ring.sv
module rstk_base_ring
  import rstk_pkg::*;
#(
  parameter int unsigned PHYS_STACKED = 128,
  localparam int unsigned PIDX_W = $clog2(PHYS_STACKED)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              back,
  input  logic [SOF_W-1:0]  step,
  output logic [PIDX_W-1:0] base
);
  logic [PIDX_W-1:0] base_d;

  always_comb begin
    base_d = base;
    if (fwd)
      base_d = PIDX_W'(ring_add(int'(base), int'(step), PHYS_STACKED));
    else if (back)
      base_d = PIDX_W'(ring_sub(int'(base), int'(step), PHYS_STACKED));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) base <= '0;
    else        base <= base_d;
  end
endmodule

// File: rtl/rstk_xlate.sv
module rstk_xlate
  import rstk_pkg::*;
#(
  parameter int unsigned PHYS_STACKED = 128,
  localparam int unsigned PIDX_W = $clog2(PHYS_STACKED)
)(
  input  logic [LREG_W-1:0] lreg,
  input  logic [SOF_W-1:0]  sof,
  input  logic [PIDX_W-1:0] base,
  output logic [PIDX_W-1:0] phys,
  output logic              is_fixed,
  output logic              beyond
);
  logic [LREG_W-1:0] offs;

  always_comb begin
    is_fixed = lreg < LREG_W'(NUM_FIXED);
    offs     = lreg - LREG_W'(NUM_FIXED);
    beyond   = !is_fixed && (offs >= sof);
    if (is_fixed)
      phys = PIDX_W'(lreg);
    else
      phys = PIDX_W'(ring_add(int'(base), int'(offs), PHYS_STACKED));
  end
endmodule

// File: rtl/rstk_frame_unit.sv
module rstk_frame_unit
  import rstk_pkg::*;
#(
  parameter int unsigned PHYS_STACKED = 128,
  localparam int unsigned PIDX_W = $clog2(PHYS_STACKED)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [1:0]          op_code,
  input  logic [6:0]          alloc_ins,
  input  logic [6:0]          alloc_locs,
  input  logic [6:0]          alloc_outs,
  input  logic [3:0]          alloc_rot,
  input  logic [6:0]          lreg,
  output logic [37:0]         cfm,
  output logic [37:0]         pfm,
  output logic                alloc_wr_valid,
  output logic [37:0]         alloc_wr_data,
  output logic                alloc_fault,
  output logic [PIDX_W-1:0]   phys_idx,
  output logic                phys_static,
  output logic                reg_fault
);
  frame_t cur_q, sav_q, cur_d, sav_d;
  frame_t alloc_frame;
  logic   alloc_ok, alloc_big, alloc_rot_bad;
  logic   ev_alloc, ev_alloc_good, ev_alloc_bad, ev_call, ev_ret;
  logic   wr_valid_q, fault_q;
  logic [MARK_W-1:0] wr_data_q;
  logic [PIDX_W-1:0] base_q;
  logic [SOF_W-1:0]  base_step;

  // Decoded events, named for the checker.
  assign ev_alloc      = op_valid && (op_code == OP_ALLOC);
  assign ev_call       = op_valid && (op_code == OP_CALL);
  assign ev_ret        = op_valid && (op_code == OP_RET);
  assign ev_alloc_good = ev_alloc && alloc_ok;
  assign ev_alloc_bad  = ev_alloc && !alloc_ok;

  rstk_alloc_eval u_eval (
    .cur        (cur_q),
    .ins        (alloc_ins),
    .locs       (alloc_locs),
    .outs       (alloc_outs),
    .rot        (alloc_rot),
    .next_frame (alloc_frame),
    .ok         (alloc_ok),
    .too_big    (alloc_big),
    .rot_over   (alloc_rot_bad)
  );

  assign base_step = ev_call ? cur_q.sol : sav_q.sol;

  rstk_base_ring #(.PHYS_STACKED(PHYS_STACKED)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .fwd   (ev_call),
    .back  (ev_ret),
    .step  (base_step),
    .base  (base_q)
  );

  always_comb begin
    cur_d = cur_q;
    sav_d = sav_q;
    unique case (1'b1)
      ev_alloc_good: cur_d = alloc_frame;
      ev_call: begin
        sav_d     = cur_q;
        cur_d     = '0;
        cur_d.sof = cur_q.sof - cur_q.sol;
      end
      ev_ret:  cur_d = sav_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      sav_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_data_q  <= '0;
      fault_q    <= 1'b0;
    end else begin
      cur_q      <= cur_d;
      sav_q      <= sav_d;
      wr_valid_q <= ev_alloc_good;
      fault_q    <= ev_alloc_bad;
      if (ev_alloc_good) wr_data_q <= sav_q;
    end
  end

  rstk_xlate #(.PHYS_STACKED(PHYS_STACKED)) u_xlate (
    .lreg     (lreg),
    .sof      (cur_q.sof),
    .base     (base_q),
    .phys     (phys_idx),
    .is_fixed (phys_static),
    .beyond   (reg_fault)
  );

  assign cfm            = cur_q;
  assign pfm            = sav_q;
  assign alloc_wr_valid = wr_valid_q;
  assign alloc_wr_data  = wr_data_q;
  assign alloc_fault    = fault_q;
endmodule

// File: rtl/rstk_frame_chk.sv
module rstk_frame_chk #(
  parameter int unsigned PHYS_STACKED = 128,
  localparam int unsigned PIDX_W = $clog2(PHYS_STACKED)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_alloc,
  input logic              ev_call,
  input logic              ev_ret,
  input logic [6:0]        lreg,
  input logic [37:0]       cfm,
  input logic [37:0]       pfm,
  input logic              alloc_wr_valid,
  input logic [37:0]       alloc_wr_data,
  input logic              alloc_fault,
  input logic [PIDX_W-1:0] phys_idx,
  input logic              phys_static,
  input logic              reg_fault
);
  a_r2_fixed_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg < 7'd32) |-> (phys_static && !reg_fault && phys_idx == PIDX_W'(lreg)));

  a_r4_alloc_keeps_saved: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> (pfm == $past(pfm)));

  a_r4_write_is_saved: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_wr_valid |-> (alloc_wr_data == pfm));

  a_r5_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fault |-> (cfm == $past(cfm) && pfm == $past(pfm)));

  a_r5_fault_or_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_fault, alloc_wr_valid}));

  a_r6_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> (pfm == $past(cfm) && cfm[13:7] == 7'd0));

  a_r7_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret |=> (cfm == $past(pfm) && pfm == $past(pfm)));

  a_r8_index_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (!phys_static && !reg_fault) |-> (int'(phys_idx) < int'(PHYS_STACKED)));

  a_r9_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_alloc && !ev_call && !ev_ret) |=> ($stable(cfm) && $stable(pfm)));
endmodule

bind rstk_frame_unit rstk_frame_chk #(.PHYS_STACKED(PHYS_STACKED)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_alloc       (ev_alloc),
  .ev_call        (ev_call),
  .ev_ret         (ev_ret),
  .lreg           (lreg),
  .cfm            (cfm),
  .pfm            (pfm),
  .alloc_wr_valid (alloc_wr_valid),
  .alloc_wr_data  (alloc_wr_data),
  .alloc_fault    (alloc_fault),
  .phys_idx       (phys_idx),
  .phys_static    (phys_static),
  .reg_fault      (reg_fault)
);

// File: tb/rstk_frame_unit_bench.sv
module rstk_frame_unit_bench;
  localparam int P  = 100;
  localparam int PW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'd3;
  logic [6:0]    a_i = '0, a_l = '0, a_o = '0;
  logic [3:0]    a_r = '0;
  logic [6:0]    lreg = '0;
  logic [37:0]   cfm, pfm, wr_data;
  logic          wr_valid, afault, pstat, rfault;
  logic [PW-1:0] pidx;

  int total = 0, bad = 0;
  // Reference model
  int m_sof = 0, m_sol = 0, m_sor = 0;
  int s_sof = 0, s_sol = 0, s_sor = 0;
  int m_base = 0;

  always #5 clk = ~clk;

  rstk_frame_unit #(.PHYS_STACKED(P)) u_rstk_frame_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .alloc_ins(a_i), .alloc_locs(a_l), .alloc_outs(a_o), .alloc_rot(a_r),
    .lreg(lreg), .cfm(cfm), .pfm(pfm), .alloc_wr_valid(wr_valid),
    .alloc_wr_data(wr_data), .alloc_fault(afault), .phys_idx(pidx),
    .phys_static(pstat), .reg_fault(rfault)
  );

  function automatic logic [37:0] mark(input int sof, input int sol, input int sor);
    return {6'd0, 7'd0, 7'd0, 4'(sor), 7'(sol), 7'(sof)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_marks(input string req);
    chk({req, " cfm"}, 64'(cfm), 64'(mark(m_sof, m_sol, m_sor)));
    chk({req, " pfm"}, 64'(pfm), 64'(mark(s_sof, s_sol, s_sor)));
  endtask

  // Sweep of every logical register: R2 for fixed, R8 for stacked.
  task automatic sweep();
    for (int n = 0; n < 128; n++) begin
      lreg = 7'(n);
      #1;
      if (n < 32) begin
        chk("R2 fixed map", {pstat, rfault, 32'(pidx)}, {1'b1, 1'b0, 32'(n)});
      end else if (n - 32 >= m_sof) begin
        chk("R8 range fault", {pstat, rfault}, {1'b0, 1'b1});
      end else begin
        chk("R8 stacked map", {pstat, rfault, 32'(pidx)},
            {1'b0, 1'b0, 32'((m_base + n - 32) % P)});
      end
    end
  endtask

  // Issue one operation; sample at the negedge after the capturing edge.
  task automatic do_op(input logic v, input logic [1:0] code,
                       input int i, input int l, input int o, input int r);
    int tot;
    logic good;
    @(negedge clk);
    op_valid = v; op_code = code;
    a_i = 7'(i); a_l = 7'(l); a_o = 7'(o); a_r = 4'(r);
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'd3;
    tot = i + l + o;
    good = (tot <= 96) && (r * 8 <= tot);
    if (v && code == 2'd0) begin
      chk("R4/R5 pulses", {wr_valid, afault}, {good, !good});
      if (good) begin
        chk("R4 write data", 64'(wr_data), 64'(mark(s_sof, s_sol, s_sor)));
        m_sof = tot; m_sol = i + l; m_sor = r;
      end
    end else begin
      chk("R9 no pulses", {wr_valid, afault}, 2'b00);
      if (v && code == 2'd1) begin
        s_sof = m_sof; s_sol = m_sol; s_sor = m_sor;
        m_base = (m_base + m_sol) % P;
        m_sof = m_sof - m_sol; m_sol = 0; m_sor = 0;
      end else if (v && code == 2'd2) begin
        m_sof = s_sof; m_sol = s_sol; m_sor = s_sor;
        m_base = (m_base - s_sol + P) % P;
      end
    end
    check_marks(v && code == 2'd1 ? "R6" : v && code == 2'd2 ? "R7" :
                v && code == 2'd0 ? (good ? "R4" : "R5") : "R9");
    sweep();
  endtask

  initial begin
    #(20000 * 10);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_marks("R1 reset");
    chk("R1 no pulses", {wr_valid, afault}, 2'b00);
    chk("R3 width", 64'($bits(cfm)), 64'd38);
    sweep();

    do_op(1, 2'd0, 2, 12, 7, 1);   // sol 14, sof 21, sor 1
    do_op(1, 2'd1, 0, 0, 0, 0);    // call: sof 7, base 14
    do_op(1, 2'd0, 7, 9, 3, 0);    // sol 16, sof 19
    do_op(1, 2'd2, 0, 0, 0, 0);    // return: 21/14, base 0
    do_op(1, 2'd0, 40, 40, 20, 0); // R5 too big
    do_op(1, 2'd0, 0, 8, 0, 2);    // R5 rotating exceeds frame
    do_op(1, 2'd0, 0, 96, 0, 12);  // full 96 frame, rot 96
    do_op(1, 2'd3, 1, 1, 1, 0);    // R9 opcode 3
    do_op(0, 2'd0, 1, 1, 1, 0);    // R9 strobe low
    do_op(0, 2'd1, 0, 0, 0, 0);    // R9 strobe low call
    do_op(1, 2'd0, 0, 60, 30, 0);
    do_op(1, 2'd1, 0, 0, 0, 0);    // base 60
    do_op(1, 2'd0, 0, 30, 40, 0);  // sof 70, wraps in map
    do_op(1, 2'd1, 0, 0, 0, 0);    // base 90
    do_op(1, 2'd0, 0, 15, 10, 0);  // map wraps past 100
    do_op(1, 2'd2, 0, 0, 0, 0);    // base back to 60
    do_op(1, 2'd1, 0, 0, 0, 0);    // base 90
    do_op(1, 2'd0, 0, 20, 5, 1);
    do_op(1, 2'd1, 0, 0, 0, 0);    // base 110 -> 10
    do_op(1, 2'd2, 0, 0, 0, 0);    // base 10 - 20 -> 90

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule